// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Nibble-Carry Flags

This block is the datapath for a small 8-bit accumulator machine. Each cycle it takes the accumulator byte `w_i`, a second byte `opnd_i` (a register value or an 8-bit literal) and an operation code. It returns a combinational result byte, a multiply high byte and a flag telling the caller whether the result is meant to be written back. A registered bank holds the zero, carry and digit-carry flags. The carry that feeds the with-carry operations and the rotates comes from this bank.

Each operation class updates only its own flags, and the others keep their value. On subtraction the carry means "no borrow". The digit carry is the carry (or no-borrow) out of the low nibble. When `valid_i` is low, the flags hold, and the combinational outputs may be ignored.

Top module: `alu8_core`

## Requirements
- R1: `rst_ni` low clears the zero, carry and digit-carry flags at once, without waiting for a clock edge.
- R2: ADD gives `result_o = (w_i + opnd_i) mod 256`. ADDC also adds the registered carry. C is the carry out of bit 7, DC is the carry out of bit 3 (carry-in included), and Z is set when the result is zero. All three flags are updated.
- R3: SUB gives `opnd_i - w_i`. SUBC also subtracts the inverted registered carry as a borrow. C is set when no borrow occurs, DC is set when the low nibble does not borrow, and Z is set when the result is zero.
- R4: SUBL (literal subtract) gives `opnd_i - w_i` with the flags of R3. Z is taken from `w_i - opnd_i`.
- R5: CMP updates C, DC and Z like SUB and drives `res_wr_o` low.
- R6: AND, OR, XOR, NOT (`~opnd_i`), INC (`opnd_i+1`), DEC (`opnd_i-1`), CLR (zero), MOVW (result `opnd_i`) and TEST (result `opnd_i`, `res_wr_o` low) update only Z.
- R7: RL gives `{opnd_i[6:0], C}` and loads C from `opnd_i[7]`. RR gives `{C, opnd_i[7:1]}` and loads C from `opnd_i[0]`. Both update only C.
- R8: SWAP exchanges `opnd_i[7:4]` and `opnd_i[3:0]` and changes no flag.
- R9: MULU and MULS form the unsigned or signed 16-bit product of `w_i` and `opnd_i`. The low byte goes to `result_o` and the high byte to `mulh_o`. No flag changes. For every other operation `mulh_o` is zero.
- R10: While `valid_i` is low, no flag changes.
- R11: MOVF gives `result_o = w_i` and changes no flag.
- R12: Operation codes on `op_i`: ADD 0, ADDC 1, SUB 2, SUBC 3, SUBL 4, CMP 5, AND 6, OR 7, XOR 8, NOT 9, INC 10, DEC 11, CLR 12, RL 13, RR 14, SWAP 15, MULU 16, MULS 17, MOVW 18, MOVF 19, TEST 20. Any other code drives a zero result, a low `res_wr_o` and changes no flag. `res_wr_o` is high for every listed operation except CMP and TEST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation applies its flag updates at the next edge |
| op_i | input | 5 | Operation code (R12) |
| w_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Register or literal operand |
| result_o | output | 8 | Result byte |
| mulh_o | output | 8 | Product high byte |
| res_wr_o | output | 1 | Result is to be written back |
| z_o | output | 1 | Registered zero flag |
| c_o | output | 1 | Registered carry flag |
| dc_o | output | 1 | Registered digit-carry flag |

## Verification
The assertions check on every cycle which flags each operation class is allowed to touch:
- flags hold when `valid_i` is low, and on swap, multiply and the W-to-register move;
- carry and digit carry survive logic operations;
- rotates leave Z and DC alone and take the carry from the shifted-out bit;
- compare never requests a write, and the high product byte is zero outside multiply.

The arithmetic values cannot be shown by those per-cycle properties and are left to the bench's scenarios, which run against the reference model:
- the nibble carry at the 0x0F/0x10 boundary;
- the no-borrow sense of carry;
- the inverted borrow-in of SUBC;
- the swapped zero test of the literal subtract;
- the signed versus unsigned product.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUB  = 5'd2,  OP_SUBC = 5'd3,
    OP_SUBL = 5'd4,  OP_CMP  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_NOT  = 5'd9,  OP_INC  = 5'd10, OP_DEC  = 5'd11,
    OP_CLR  = 5'd12, OP_RL   = 5'd13, OP_RR   = 5'd14, OP_SWAP = 5'd15,
    OP_MULU = 5'd16, OP_MULS = 5'd17, OP_MOVW = 5'd18, OP_MOVF = 5'd19,
    OP_TEST = 5'd20
  } alu_op_e;

  localparam int FLAG_N = 3;
  localparam int FZ  = 2;
  localparam int FC  = 1;
  localparam int FDC = 0;
endpackage

// File: rtl/alu8_addsub.sv
// a + b + cin, or a + ~b + cin for subtract (carry out = no borrow)
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          co_o,
  output logic          hco_o
);
  localparam int NW = DW / 2;

  logic [DW-1:0] bx;
  logic [DW:0]   full;
  logic [NW:0]   low;

  assign bx    = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, bx} + {{DW{1'b0}}, cin_i};
  assign low   = {1'b0, a_i[NW-1:0]} + {1'b0, bx[NW-1:0]} + {{NW{1'b0}}, cin_i};
  assign sum_o = full[DW-1:0];
  assign co_o  = full[DW];
  assign hco_o = low[NW];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] w_i,
  input  logic [DW-1:0] f_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          co_o
);
  localparam int NW = DW / 2;

  always_comb begin
    res_o = '0;
    co_o  = cin_i;
    unique case (op_i)
      OP_AND:  res_o = w_i & f_i;
      OP_OR:   res_o = w_i | f_i;
      OP_XOR:  res_o = w_i ^ f_i;
      OP_NOT:  res_o = ~f_i;
      OP_INC:  res_o = f_i + 1'b1;
      OP_DEC:  res_o = f_i - 1'b1;
      OP_CLR:  res_o = '0;
      OP_RL: begin
        res_o = {f_i[DW-2:0], cin_i};
        co_o  = f_i[DW-1];
      end
      OP_RR: begin
        res_o = {cin_i, f_i[DW-1:1]};
        co_o  = f_i[0];
      end
      OP_SWAP: res_o = {f_i[NW-1:0], f_i[DW-1:NW]};
      OP_MOVW: res_o = f_i;
      OP_TEST: res_o = f_i;
      OP_MOVF: res_o = w_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_mult.sv
module alu8_mult #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            signed_i,
  output logic [2*DW-1:0] prod_o
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] ax, bx;
  logic [2*PW-1:0] full;

  // sign-extend to product width; low PW bits are correct for both forms
  assign ax     = {{DW{signed_i & a_i[DW-1]}}, a_i};
  assign bx     = {{DW{signed_i & b_i[DW-1]}}, b_i};
  assign full   = {{PW{1'b0}}, ax} * {{PW{1'b0}}, bx};
  assign prod_o = full[PW-1:0];
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] we_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o[i] <= 1'b0;
      else if (we_i[i]) q_o[i] <= d_i[i];
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] w_i,
  input  logic [DW-1:0] opnd_i,
  output logic [DW-1:0] result_o,
  output logic [DW-1:0] mulh_o,
  output logic          res_wr_o,
  output logic          z_o,
  output logic          c_o,
  output logic          dc_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [FLAG_N-1:0] flag_q, flag_d, flag_we, mask;

  logic          is_sub, use_c, as_cin, as_co, as_hco, lg_co, mul_s;
  logic [DW-1:0] as_a, as_b, as_sum, lg_res;
  logic [2*DW-1:0] prod;

  assign is_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_SUBL) || (op == OP_CMP);
  assign use_c  = (op == OP_ADDC) || (op == OP_SUBC);
  assign as_cin = use_c ? flag_q[FC] : is_sub;
  assign as_a   = is_sub ? opnd_i : w_i;
  assign as_b   = is_sub ? w_i : opnd_i;
  assign mul_s  = (op == OP_MULS);

  alu8_addsub #(.DW(DW)) u_addsub (
    .a_i(as_a), .b_i(as_b), .sub_i(is_sub), .cin_i(as_cin),
    .sum_o(as_sum), .co_o(as_co), .hco_o(as_hco)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op_i(op), .w_i(w_i), .f_i(opnd_i), .cin_i(flag_q[FC]),
    .res_o(lg_res), .co_o(lg_co)
  );

  alu8_mult #(.DW(DW)) u_mult (
    .a_i(w_i), .b_i(opnd_i), .signed_i(mul_s), .prod_o(prod)
  );

  always_comb begin
    result_o = '0;
    mulh_o   = '0;
    res_wr_o = 1'b0;
    flag_d   = flag_q;
    mask     = '0;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_SUBL, OP_CMP: begin
        result_o     = as_sum;
        res_wr_o     = (op != OP_CMP);
        // zero of a-b equals zero of b-a, so one test serves SUBL and CMP
        flag_d[FZ]   = (as_sum == '0);
        flag_d[FC]   = as_co;
        flag_d[FDC]  = as_hco;
        mask         = '1;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_INC, OP_DEC, OP_CLR, OP_MOVW, OP_TEST: begin
        result_o   = lg_res;
        res_wr_o   = (op != OP_TEST);
        flag_d[FZ] = (lg_res == '0);
        mask[FZ]   = 1'b1;
      end
      OP_RL, OP_RR: begin
        result_o   = lg_res;
        res_wr_o   = 1'b1;
        flag_d[FC] = lg_co;
        mask[FC]   = 1'b1;
      end
      OP_SWAP, OP_MOVF: begin
        result_o = lg_res;
        res_wr_o = 1'b1;
      end
      OP_MULU, OP_MULS: begin
        result_o = prod[DW-1:0];
        mulh_o   = prod[2*DW-1:DW];
        res_wr_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign flag_we = valid_i ? mask : '0;

  alu8_flags #(.N(FLAG_N)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(flag_we), .d_i(flag_d), .q_o(flag_q)
  );

  assign z_o  = flag_q[FZ];
  assign c_o  = flag_q[FC];
  assign dc_o = flag_q[FDC];
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [4:0]    op_i,
  input logic [DW-1:0] w_i,
  input logic [DW-1:0] opnd_i,
  input logic [DW-1:0] result_o,
  input logic [DW-1:0] mulh_o,
  input logic          res_wr_o,
  input logic          z_o,
  input logic          c_o,
  input logic          dc_o
);
  logic [2:0] fl;
  logic is_logic, is_mul, is_rot;
  assign fl       = {z_o, c_o, dc_o};
  assign is_logic = op_i inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_INC, OP_DEC,
                                 OP_CLR, OP_MOVW, OP_TEST};
  assign is_mul   = (op_i == OP_MULU) || (op_i == OP_MULS);
  assign is_rot   = (op_i == OP_RL) || (op_i == OP_RR);

  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_clear: assert (fl == 3'b000);

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(fl));

  a_r8_swap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_SWAP |=> $stable(fl));

  a_r9_mul_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_mul |=> $stable(fl));

  a_r9_mulh_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_mul |-> mulh_o == '0);

  a_r11_movf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_MOVF |=> $stable(fl));

  a_r6_logic_keeps_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_logic |=> $stable({c_o, dc_o}));

  a_r7_rot_keeps_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_rot |=> $stable({z_o, dc_o}));

  a_r7_rl_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_RL |=> c_o == $past(opnd_i[DW-1]));

  a_r5_cmp_nowrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_CMP |-> !res_wr_o);

  a_r2_add_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_ADD |=> z_o == ($past(result_o) == '0));

  a_r2_add_wrap_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_ADD && result_o < w_i |=> c_o);
endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] w_i = '0, opnd_i = '0;
  logic [7:0] result_o, mulh_o;
  logic res_wr_o, z_o, c_o, dc_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int mz = 0, mc = 0, mdc = 0;

  alu8_core dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model: returns result, high byte, write flag, new flags, mask
  task automatic model(input int op, input int w, input int f,
                       output int res, output int mh, output int wr,
                       output int nz, output int nc, output int ndc, output int msk);
    int b;
    res = 0; mh = 0; wr = 0; nz = mz; nc = mc; ndc = mdc; msk = 0;
    case (op)
      0, 1: begin
        b = (op == 1) ? mc : 0;
        res = (w + f + b) & 255; wr = 1;
        nc = (w + f + b) > 255; ndc = ((w & 15) + (f & 15) + b) > 15;
        nz = (res == 0); msk = 7;
      end
      2, 3, 4, 5: begin
        b = (op == 3) ? (1 - mc) : 0;
        res = (f - w - b) & 255; wr = (op != 5);
        nc = (f >= w + b); ndc = ((f & 15) >= (w & 15) + b);
        nz = (op == 4 || op == 5) ? (((w - f) & 255) == 0) : (res == 0);
        msk = 7;
      end
      6, 7, 8, 9, 10, 11, 12, 18, 20: begin
        case (op)
          6: res = w & f;
          7: res = w | f;
          8: res = w ^ f;
          9: res = (~f) & 255;
          10: res = (f + 1) & 255;
          11: res = (f - 1) & 255;
          12: res = 0;
          default: res = f;
        endcase
        wr = (op != 20); nz = (res == 0); msk = 4;
      end
      13: begin res = ((f << 1) & 255) | mc; nc = (f >> 7) & 1; wr = 1; msk = 2; end
      14: begin res = (mc << 7) | (f >> 1); nc = f & 1; wr = 1; msk = 2; end
      15: begin res = ((f << 4) & 240) | (f >> 4); wr = 1; end
      16: begin b = w * f; res = b & 255; mh = (b >> 8) & 255; wr = 1; end
      17: begin
        b = ((w > 127) ? w - 256 : w) * ((f > 127) ? f - 256 : f);
        res = b & 255; mh = (b >> 8) & 255; wr = 1;
      end
      19: begin res = w; wr = 1; end
      default: ;
    endcase
  endtask

  function automatic string req_of(int op);
    case (op)
      0, 1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5: return "R5";
      6, 7, 8, 9, 10, 11, 12, 18, 20: return "R6";
      13, 14: return "R7";
      15: return "R8";
      16, 17: return "R9";
      19: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic step(int op, int w, int f, bit v);
    int res, mh, wr, nz, nc, ndc, msk;
    string r;
    @(negedge clk_i);
    op_i = op[4:0]; w_i = w[7:0]; opnd_i = f[7:0]; valid_i = v;
    #1;
    model(op, w, f, res, mh, wr, nz, nc, ndc, msk);
    r = v ? req_of(op) : "R10";
    check(r, "result", int'(result_o), res);
    check(r, "mulh", int'(mulh_o), mh);
    check(r, "res_wr", int'(res_wr_o), wr);
    @(posedge clk_i); #1;
    if (v) begin
      if (msk[2]) mz = nz;
      if (msk[1]) mc = nc;
      if (msk[0]) mdc = ndc;
    end
    check(r, "flags", int'({z_o, c_o, dc_o}), (mz << 2) | (mc << 1) | mdc);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 check("R1", "reset flags", int'({z_o, c_o, dc_o}), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    step(0, 8'h0F, 8'h01, 1);   // R2 nibble carry only
    step(0, 8'hFF, 8'h01, 1);   // R2 carry, zero, nibble carry
    step(1, 8'h10, 8'h20, 1);   // R2 carry-in used
    step(2, 8'h01, 8'h10, 1);   // R3 no borrow, nibble borrow
    step(2, 8'h02, 8'h01, 1);   // R3 borrow -> C=0
    step(3, 8'h01, 8'h05, 1);   // R3 SUBC with C=0 borrows extra
    step(0, 8'h80, 8'h80, 1);   // set C
    step(3, 8'h01, 8'h05, 1);   // R3 SUBC with C=1
    step(4, 8'h30, 8'h30, 1);   // R4 equal -> Z
    step(4, 8'h05, 8'h03, 1);   // R4 literal below W
    step(5, 8'h44, 8'h44, 1);   // R5 compare equal
    step(6, 8'hF0, 8'h0F, 1);   // R6 AND zero
    step(9, 8'h00, 8'hFF, 1);   // R6 NOT zero
    step(10, 8'h00, 8'hFF, 1);  // R6 INC wraps
    step(13, 8'h00, 8'h81, 1);  // R7 rotate left
    step(14, 8'h00, 8'h02, 1);  // R7 rotate right
    step(15, 8'h00, 8'hA5, 1);  // R8 swap
    step(16, 8'hFF, 8'hFF, 1);  // R9 unsigned product
    step(17, 8'hFF, 8'h02, 1);  // R9 signed product
    step(19, 8'h5A, 8'h00, 1);  // R11 move W out
    step(20, 8'h00, 8'h00, 1);  // R6 test, no write
    step(0, 8'hFF, 8'hFF, 0);   // R10 idle
    step(23, 8'h12, 8'h34, 1);  // R12 unused code
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 23), $urandom_range(0, 255), $urandom_range(0, 255),
           ($urandom_range(0, 7) != 0));
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check("R1", "async reset flags", int'({z_o, c_o, dc_o}), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule